// File: doc/BRIEF.md
# Decimal Result Serial Printer

This block reports a signed 32-bit result word as human-readable text on an asynchronous serial line. A single-cycle start strobe, typically raised when a processor core halts, captures the value. The block then writes its decimal representation as ASCII characters, most significant digit first, and ends the line with a carriage return and a line feed. Small numeric codes, such as trap numbers, travel the same path.

The conversion is sequential. Each decimal place is found by subtracting the matching power of ten repeatedly, one subtraction per clock cycle, so no wide combinational divider is needed. Leading zeros are dropped, zero prints as a single `0`, and negative values get a leading minus sign followed by the magnitude. The most negative value is handled correctly. The bit period comes from the system clock frequency and baud rate parameters (50 MHz and 115200 by default). Every character is sent as one 8N1 frame.

Top module: `decPrinter`

## Requirements
- R1: Each byte is sent as one frame: a low start bit, then 8 data bits with the least significant bit first, then a high stop bit. Every bit lasts CLK_HZ/BAUD clock cycles (integer division).
- R2: A start pulse while idle begins a printout. `busy` is high in the cycle after the pulse and stays high until the stop bit of the final line feed has completed.
- R3: Each digit d is sent as the byte 0x30+d, most significant digit first. The digits are followed by 0x0D and then 0x0A.
- R4: Leading zeros are not sent, and the value 0 prints as the single byte 0x30.
- R5: A negative value (bit 31 set, two's complement) prints 0x2D ('-') first, followed by the digits of its magnitude. 0x80000000 prints as "-2147483648".
- R6: A start pulse that arrives while `busy` is high is ignored. The text in progress is unchanged, and no extra text follows it.
- R7: The value 6765 produces exactly 0x36 0x37 0x36 0x35 0x0D 0x0A, and the value 3 produces exactly 0x33 0x0D 0x0A.
- R8: After reset, and whenever `busy` is low, the serial line is high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| resultValue | input | 32 | Signed value to print, sampled on the start pulse |
| startPulse | input | 1 | One-cycle request to print `resultValue` |
| busy | output | 1 | High while a printout is in progress |
| serialOut | output | 1 | Asynchronous serial transmit line, idles high |

## Verification
The hardest case to reach from the ports is a second start pulse that lands in the middle of a printout. This matters most on a long negative value, where the minus sign and the digit frames leave a wide window. The bench runs a serial receiver in one branch of a fork. In the other branch, part-way through the text, it pulses start with a different value. It then checks that the received string matches only the first value and that the line stays idle afterwards. The most negative value, which has no positive counterpart in 32 bits, and values with inner zeros are sent as well. Together they exercise the digit-suppression logic on both sides of the first non-zero digit.

// File: rtl/decPrinterPkg.sv
package decPrinterPkg;

  typedef enum logic [1:0] {
    SEL_MINUS,
    SEL_DIGIT,
    SEL_CR,
    SEL_LF
  } byteSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     subStep;
    logic     digitDone;
    logic     sendByte;
    byteSel_e sel;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic negative;
    logic canSub;
    logic lastPow;
    logic digitVisible;
    logic txActive;
  } dpStat_t;

endpackage

// File: rtl/decPrinterDatapath.sv
module decPrinterDatapath
  import decPrinterPkg::*;
#(
  parameter int VALUE_W = 32,
  parameter int DIGITS  = 10,
  parameter int DIV     = 434
) (
  input  logic               clk,
  input  logic               rst,
  input  dpCtrl_t            ctl,
  input  logic [VALUE_W-1:0] value,
  output dpStat_t            stat,
  output logic               txd
);

  localparam int IDX_W   = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int BAUD_W  = $clog2(DIV + 1);
  localparam int FRAME_W = 10;

  function automatic logic [VALUE_W-1:0] powTen(input int idx);
    longint p;
    p = 1;
    for (int i = 0; i < idx; i++) p = p * 10;
    return p[VALUE_W-1:0];
  endfunction

  logic [VALUE_W-1:0] powTable [DIGITS];
  for (genvar g = 0; g < DIGITS; g++) begin : g_pow
    assign powTable[g] = powTen(g);
  end

  logic [VALUE_W-1:0] magReg;
  logic               negReg;
  logic [IDX_W-1:0]   powIdx;
  logic [3:0]         digitCnt;
  logic               seenNonZero;
  logic [FRAME_W-1:0] shiftReg;
  logic [3:0]         bitCnt;
  logic [BAUD_W-1:0]  baudCnt;
  logic               txActive;
  logic [VALUE_W-1:0] curPow;
  logic [7:0]         txByte;

  assign curPow = powTable[powIdx];

  always_comb begin
    unique case (ctl.sel)
      SEL_MINUS: txByte = 8'h2D;
      SEL_DIGIT: txByte = 8'h30 + {4'h0, digitCnt};
      SEL_CR:    txByte = 8'h0D;
      default:   txByte = 8'h0A;
    endcase
  end

  // conversion registers
  always_ff @(posedge clk) begin
    if (rst) begin
      magReg      <= '0;
      negReg      <= 1'b0;
      powIdx      <= '0;
      digitCnt    <= '0;
      seenNonZero <= 1'b0;
    end else if (ctl.load) begin
      negReg      <= value[VALUE_W-1];
      magReg      <= value[VALUE_W-1] ? (~value + 1'b1) : value;
      powIdx      <= IDX_W'(DIGITS - 1);
      digitCnt    <= '0;
      seenNonZero <= 1'b0;
    end else if (ctl.subStep) begin
      magReg   <= magReg - curPow;
      digitCnt <= digitCnt + 4'd1;
    end else if (ctl.digitDone) begin
      if (digitCnt != 4'd0) seenNonZero <= 1'b1;
      digitCnt <= '0;
      if (powIdx != '0) powIdx <= powIdx - 1'b1;
    end
  end

  // serial framer
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '1;
      bitCnt   <= '0;
      baudCnt  <= '0;
      txActive <= 1'b0;
    end else if (ctl.sendByte) begin
      shiftReg <= {1'b1, txByte, 1'b0};
      bitCnt   <= '0;
      baudCnt  <= '0;
      txActive <= 1'b1;
    end else if (txActive) begin
      if (baudCnt == BAUD_W'(DIV - 1)) begin
        baudCnt  <= '0;
        shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
        bitCnt   <= bitCnt + 4'd1;
        if (bitCnt == 4'(FRAME_W - 1)) txActive <= 1'b0;
      end else begin
        baudCnt <= baudCnt + 1'b1;
      end
    end
  end

  assign txd = txActive ? shiftReg[0] : 1'b1;

  assign stat.negative     = negReg;
  assign stat.canSub       = (magReg >= curPow);
  assign stat.lastPow      = (powIdx == '0);
  assign stat.digitVisible = (digitCnt != 4'd0) || seenNonZero || (powIdx == '0);
  assign stat.txActive     = txActive;

  // R1: the last bit of a frame is the high stop bit
  p_stop_high_r1: assert property (@(posedge clk) disable iff (rst)
    (txActive && bitCnt == 4'(FRAME_W - 1)) |-> txd);

  // R1: a new byte is only loaded once the previous frame is over
  p_send_gap_r1: assert property (@(posedge clk) disable iff (rst)
    ctl.sendByte |-> !txActive);

  // R3: repeated subtraction never yields a digit above nine
  p_digit_range_r3: assert property (@(posedge clk) disable iff (rst)
    digitCnt <= 4'd9);

  // R6: a new value is only captured while the line is quiet
  p_load_idle_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.load |-> !txActive);

endmodule

// File: rtl/decPrinterCtrl.sv
module decPrinterCtrl
  import decPrinterPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    startPulse,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    busy
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_SIGN,
    S_CALC,
    S_CR,
    S_LF,
    S_WAIT
  } state_e;

  state_e state, nextState, retState, retNext;

  always_comb begin
    ctl       = '0;
    ctl.sel   = SEL_DIGIT;
    nextState = state;
    retNext   = retState;
    unique case (state)
      S_IDLE: begin
        if (startPulse) begin
          ctl.load  = 1'b1;
          nextState = S_SIGN;
        end
      end
      S_SIGN: begin
        if (stat.negative) begin
          ctl.sendByte = 1'b1;
          ctl.sel      = SEL_MINUS;
          retNext      = S_CALC;
          nextState    = S_WAIT;
        end else begin
          nextState = S_CALC;
        end
      end
      S_CALC: begin
        if (stat.canSub) begin
          ctl.subStep = 1'b1;
        end else if (stat.digitVisible) begin
          ctl.sendByte  = 1'b1;
          ctl.sel       = SEL_DIGIT;
          ctl.digitDone = 1'b1;
          retNext       = stat.lastPow ? S_CR : S_CALC;
          nextState     = S_WAIT;
        end else begin
          ctl.digitDone = 1'b1;
        end
      end
      S_CR: begin
        ctl.sendByte = 1'b1;
        ctl.sel      = SEL_CR;
        retNext      = S_LF;
        nextState    = S_WAIT;
      end
      S_LF: begin
        ctl.sendByte = 1'b1;
        ctl.sel      = SEL_LF;
        retNext      = S_IDLE;
        nextState    = S_WAIT;
      end
      default: begin
        if (!stat.txActive) nextState = retState;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      retState <= S_IDLE;
    end else begin
      state    <= nextState;
      retState <= retNext;
    end
  end

  assign busy = (state != S_IDLE);

  // R2: a start pulse while idle raises busy on the next cycle
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (startPulse && !busy) |=> busy);

  // R2: entering the wait state always finds a frame on the wire
  p_wait_tx_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && $past(state) != S_WAIT) |-> stat.txActive);

endmodule

// File: rtl/decPrinter.sv
module decPrinter
  import decPrinterPkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int BAUD    = 115_200,
  parameter int VALUE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VALUE_W-1:0] resultValue,
  input  logic               startPulse,
  output logic               busy,
  output logic               serialOut
);

  function automatic int countDigits(input int w);
    longint m;
    int n;
    m = longint'(1) << (w - 1);
    n = 0;
    while (m > 0) begin
      n++;
      m = m / 10;
    end
    return n;
  endfunction

  localparam int DIV    = (CLK_HZ / BAUD > 0) ? CLK_HZ / BAUD : 1;
  localparam int DIGITS = countDigits(VALUE_W);

  dpCtrl_t ctl;
  dpStat_t stat;

  decPrinterCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .startPulse(startPulse),
    .stat      (stat),
    .ctl       (ctl),
    .busy      (busy)
  );

  decPrinterDatapath #(
    .VALUE_W(VALUE_W),
    .DIGITS (DIGITS),
    .DIV    (DIV)
  ) u_dp (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ctl),
    .value(resultValue),
    .stat (stat),
    .txd  (serialOut)
  );

  // R8: the line rests high whenever no printout is running
  p_idle_line_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> serialOut);

endmodule

// File: tb/decPrinter_bench.sv
module decPrinter_bench;

  localparam int CLK_HZ = 50_000_000;
  localparam int BAUD   = 5_000_000;
  localparam int DIV    = CLK_HZ / BAUD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] resultValue = '0;
  logic        startPulse = 1'b0;
  logic        busy;
  logic        serialOut;

  int tests = 0;
  int fails = 0;
  int idleBad = 0;
  bit live = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  decPrinter #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .VALUE_W(32)) u_decPrinter (
    .clk(clk), .rst(rst), .resultValue(resultValue),
    .startPulse(startPulse), .busy(busy), .serialOut(serialOut)
  );

  // per-clock model: idle line must be high (R8)
  always @(negedge clk) begin
    if (live && !busy && serialOut !== 1'b1) idleBad++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // receive one frame, R1: start low, LSB first, stop high, DIV cycles per bit
  task automatic getByte(output int b, output bit ok);
    int waitCnt;
    ok = 1'b1;
    b = 0;
    waitCnt = 0;
    @(negedge clk);
    while (serialOut !== 1'b0) begin
      waitCnt++;
      if (waitCnt > 40 * DIV) begin
        ok = 1'b0;
        return;
      end
      @(negedge clk);
    end
    repeat (DIV / 2) @(negedge clk);
    if (serialOut !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = serialOut;
    end
    repeat (DIV) @(negedge clk);
    if (serialOut !== 1'b1) ok = 1'b0;
  endtask

  task automatic pulseStart(input logic [31:0] v);
    @(negedge clk);
    resultValue = v;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic receiveText(input string exp, input string req);
    int b;
    bit ok;
    for (int i = 0; i < exp.len(); i++) begin
      getByte(b, ok);
      check(ok, "R1", "frame shape", ok, 1);
      check(b == int'(exp[i]), req, $sformatf("byte %0d", i), b, int'(exp[i]));
      if (i == exp.len() - 1) begin
        check(busy === 1'b1, "R2", "busy during final stop bit", busy, 1);
        repeat (DIV) @(negedge clk);
        check(busy === 1'b0, "R2", "busy released after line feed", busy, 0);
      end
    end
  endtask

  task automatic printOne(input logic [31:0] v, input string req);
    string exp;
    exp = $sformatf("%0d", $signed(v));
    exp = {exp, "\r\n"};
    @(negedge clk);
    resultValue = v;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(busy === 1'b1, "R2", "busy after start", busy, 1);
    receiveText(exp, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    live = 1'b1;
    check(busy === 1'b0, "R8", "busy after reset", busy, 0);
    check(serialOut === 1'b1, "R8", "line after reset", serialOut, 1);

    printOne(32'd6765, "R7");
    printOne(32'd3, "R7");
    printOne(32'd0, "R4");
    printOne(32'd1000000007, "R4");
    printOne(32'd10, "R3");
    printOne(32'd2147483647, "R3");
    printOne(32'hFFFFFFFF, "R5");
    printOne(32'h80000000, "R5");
    printOne(-32'sd90210, "R5");

    // R6: a second start mid-print must not disturb the text
    @(negedge clk);
    resultValue = -32'sd123456;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    fork
      receiveText("-123456\r\n", "R6");
      begin
        repeat (25 * DIV) @(negedge clk);
        pulseStart(32'd999);
      end
    join
    repeat (30 * DIV) @(negedge clk);
    check(serialOut === 1'b1 && busy === 1'b0, "R6", "no text after ignored start",
          {serialOut, busy}, 2);

    check(idleBad == 0, "R8", "idle line high on every clock", idleBad, 0);
    summary();
  end

endmodule